// File: doc/BRIEF.md
# Cascaded Interrupt Source Resolver

This block is the decode stage of a three-bank interrupt controller. Bank 0 holds three kinds of bit: eight direct sources, two summary flags that stand for the two cascaded 32-bit banks, and eleven shortcut flags. Each shortcut flag is a copy of one specific source in bank 1 or bank 2. Software running a handler loop would otherwise read bank 0, decide which group to look at, and perhaps read a second word. This block does that whole decision in one step. It returns the one source that should be serviced next.

A one-cycle strobe captures the three pending words. On the following cycle the block presents the result. That result is a completion pulse, a found flag, an error flag, and a 7-bit source code that packs a bank number and a bit number. The result holds until the next strobe. A handler loop strobes, services the source it gets, and strobes again until the found flag stays low.

Top module: `irq_source_resolver`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs `done_o`, `valid_o`, `err_o` and `code_o` are all zero until the first strobe.
- R2: A strobe on `sample_i` makes `done_o` high for exactly the next cycle. The result then reflects the pending words present at that strobe. Input changes without a strobe leave `valid_o`, `err_o` and `code_o` unchanged.
- R3: `code_o` is bank × 32 + bit. Bits 6:5 carry the bank (0, 1 or 2) and bits 4:0 carry the source number within that bank.
- R4: Bits 31:21 of `pend0_i` never influence the result. If bits 20:0 of `pend0_i` are all zero, then `valid_o` and `err_o` are both low and `code_o` is zero.
- R5: Any set bit among `pend0_i[7:0]` wins over all other bits. The result is bank 0 and the lowest such bit index.
- R6: With no direct bit set, the lowest set bit among `pend0_i[14:10]` wins. Positions 0 to 4 of that group report bank 1 sources 7, 9, 10, 18 and 19.
- R7: Next comes the lowest set bit among `pend0_i[20:15]`. Positions 0 to 5 of that group report bank 2 sources 21, 22, 23, 24, 25 and 30.
- R8: Next, if `pend0_i[8]` is set, the result is bank 1 and the lowest set bit of `pend1_i`.
- R9: Last, if `pend0_i[9]` is set, the result is bank 2 and the lowest set bit of `pend2_i`.
- R10: A summary bit can decide the search while its bank word is zero. In that case `err_o` goes high, `valid_o` stays low and `code_o` is zero. The search does not move on to the other summary bit.
- R11: `valid_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Strobe: capture and resolve the pending words |
| pend0_i | input | 32 | Bank 0 pending word (direct, summary, shortcut bits) |
| pend1_i | input | 32 | Bank 1 pending word |
| pend2_i | input | 32 | Bank 2 pending word |
| done_o | output | 1 | Pulses one cycle after each strobe |
| valid_o | output | 1 | A source was found |
| err_o | output | 1 | A summary bit was set with an empty bank word |
| code_o | output | 7 | Resolved source, bank in bits 6:5, bit in bits 4:0 |

## Verification
The properties assume that the pending words are stable around the strobe edge. They also assume that nothing is known about them between strobes. For that reason every check on the result is keyed to `sample_i`, and checks away from a strobe only demand that the outputs hold. The stimulus drives new words and the strobe together on the falling edge. After each strobe it inverts all three words without a strobe, so that hold violations show up. The sweeps also set arbitrary values in the ignored upper bits of bank 0 and in the cascaded words. They include summary-only cases with empty bank words, so that the error path is reached.

// File: rtl/irq_res_pkg.sv
`timescale 1ns/1ps
package irq_res_pkg;

  parameter int WORD_W  = 32;
  parameter int BANK_W  = 2;
  parameter int BIT_W   = 5;
  parameter int CODE_W  = BANK_W + BIT_W;

  // bank 0 layout (positions are decoded behaviour)
  parameter int DIR_LO  = 0;
  parameter int DIR_N   = 8;
  parameter int SUM1_AT = 8;
  parameter int SUM2_AT = 9;
  parameter int SC1_LO  = 10;
  parameter int SC1_N   = 5;
  parameter int SC2_LO  = 15;
  parameter int SC2_N   = 6;
  parameter int CASC_N  = 2;
  parameter int POS_W   = 3;

  typedef struct packed {
    logic                 valid;
    logic                 err;
    logic [BANK_W-1:0]    bank;
    logic [BIT_W-1:0]     bitn;
  } res_t;

  // shortcut position -> real source number in its cascaded bank
  function automatic logic [BIT_W-1:0] sc_lookup(input int grp, input logic [POS_W-1:0] pos);
    logic [BIT_W-1:0] s;
    s = '0;
    if (grp == 1) begin
      case (pos)
        3'd0: s = 5'd7;
        3'd1: s = 5'd9;
        3'd2: s = 5'd10;
        3'd3: s = 5'd18;
        3'd4: s = 5'd19;
        default: s = '0;
      endcase
    end else begin
      case (pos)
        3'd0: s = 5'd21;
        3'd1: s = 5'd22;
        3'd2: s = 5'd23;
        3'd3: s = 5'd24;
        3'd4: s = 5'd25;
        3'd5: s = 5'd30;
        default: s = '0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_lsb_find.sv
`timescale 1ns/1ps
module irq_lsb_find #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_sc_remap.sv
`timescale 1ns/1ps
module irq_sc_remap
  import irq_res_pkg::*;
#(
  parameter int GROUP = 1
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [BIT_W-1:0] src_o
);

  always_comb begin
    src_o = sc_lookup(GROUP, pos_i);
  end

endmodule

// File: rtl/irq_res_select.sv
`timescale 1ns/1ps
module irq_res_select
  import irq_res_pkg::*;
(
  input  logic [WORD_W-1:0] pend0_i,
  input  logic [WORD_W-1:0] pend1_i,
  input  logic [WORD_W-1:0] pend2_i,
  output res_t              res_o
);

  localparam int DIR_IW = $clog2(DIR_N);
  localparam int WRD_IW = $clog2(WORD_W);

  logic [DIR_N-1:0]  dir_v;
  logic [SC1_N-1:0]  sc1_v;
  logic [SC2_N-1:0]  sc2_v;

  logic              dir_f, sc1_f, sc2_f;
  logic [DIR_IW-1:0] dir_idx;
  logic [POS_W-1:0]  sc1_pos, sc2_pos;
  logic [BIT_W-1:0]  sc1_src, sc2_src;

  logic [WORD_W-1:0] casc_w   [CASC_N];
  logic              casc_f   [CASC_N];
  logic [WRD_IW-1:0] casc_idx [CASC_N];
  logic [CASC_N-1:0] sum_v;

  assign dir_v     = pend0_i[DIR_LO +: DIR_N];
  assign sc1_v     = pend0_i[SC1_LO +: SC1_N];
  assign sc2_v     = pend0_i[SC2_LO +: SC2_N];
  assign sum_v     = {pend0_i[SUM2_AT], pend0_i[SUM1_AT]};
  assign casc_w[0] = pend1_i;
  assign casc_w[1] = pend2_i;

  irq_lsb_find #(.W(DIR_N)) u_dir (
    .vec_i(dir_v), .found_o(dir_f), .idx_o(dir_idx)
  );

  irq_lsb_find #(.W(SC1_N), .IW(POS_W)) u_sc1 (
    .vec_i(sc1_v), .found_o(sc1_f), .idx_o(sc1_pos)
  );

  irq_lsb_find #(.W(SC2_N), .IW(POS_W)) u_sc2 (
    .vec_i(sc2_v), .found_o(sc2_f), .idx_o(sc2_pos)
  );

  irq_sc_remap #(.GROUP(1)) u_map1 (.pos_i(sc1_pos), .src_o(sc1_src));
  irq_sc_remap #(.GROUP(2)) u_map2 (.pos_i(sc2_pos), .src_o(sc2_src));

  for (genvar b = 0; b < CASC_N; b++) begin : g_casc
    irq_lsb_find #(.W(WORD_W)) u_bank (
      .vec_i(casc_w[b]), .found_o(casc_f[b]), .idx_o(casc_idx[b])
    );
  end

  // fixed search order: direct, shortcut 1, shortcut 2, summary 1, summary 2
  always_comb begin
    res_o = '0;
    if (dir_f) begin
      res_o.valid = 1'b1;
      res_o.bank  = BANK_W'(0);
      res_o.bitn  = BIT_W'(dir_idx);
    end else if (sc1_f) begin
      res_o.valid = 1'b1;
      res_o.bank  = BANK_W'(1);
      res_o.bitn  = sc1_src;
    end else if (sc2_f) begin
      res_o.valid = 1'b1;
      res_o.bank  = BANK_W'(2);
      res_o.bitn  = sc2_src;
    end else if (sum_v[0]) begin
      if (casc_f[0]) begin
        res_o.valid = 1'b1;
        res_o.bank  = BANK_W'(1);
        res_o.bitn  = BIT_W'(casc_idx[0]);
      end else begin
        res_o.err = 1'b1;
      end
    end else if (sum_v[1]) begin
      if (casc_f[1]) begin
        res_o.valid = 1'b1;
        res_o.bank  = BANK_W'(2);
        res_o.bitn  = BIT_W'(casc_idx[1]);
      end else begin
        res_o.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_source_resolver.sv
`timescale 1ns/1ps
module irq_source_resolver
  import irq_res_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [WORD_W-1:0] pend0_i,
  input  logic [WORD_W-1:0] pend1_i,
  input  logic [WORD_W-1:0] pend2_i,
  output logic              done_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);

  res_t res_comb;
  res_t res_q, res_d;
  logic done_q, done_d;

  irq_res_select u_sel (
    .pend0_i(pend0_i),
    .pend1_i(pend1_i),
    .pend2_i(pend2_i),
    .res_o  (res_comb)
  );

  always_comb begin
    done_d = sample_i;
    res_d  = res_q;
    if (sample_i) res_d = res_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign done_o  = done_q;
  assign valid_o = res_q.valid;
  assign err_o   = res_q.err;
  assign code_o  = {res_q.bank, res_q.bitn};

endmodule

// File: rtl/irq_source_resolver_chk.sv
`timescale 1ns/1ps
module irq_source_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_i,
  input logic [31:0] pend0_i,
  input logic [31:0] pend1_i,
  input logic [31:0] pend2_i,
  input logic        done_o,
  input logic        valid_o,
  input logic        err_o,
  input logic [6:0]  code_o
);

  // R2
  strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> done_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> (!done_o && $stable(code_o) && $stable(valid_o) && $stable(err_o)));

  // R11
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  // R3
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (code_o[6:5] != 2'b11));

  // R5
  bank0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && code_o[6:5] == 2'b00) |-> (code_o[4:0] < 5'd8));

  // R4
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && pend0_i[20:0] == 21'd0) |=> (!valid_o && !err_o && code_o == 7'd0));

  // R10
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (code_o == 7'd0));

  // R6
  sc1_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && pend0_i[7:0] == 8'd0 && pend0_i[14:10] != 5'd0)
      |=> (valid_o && code_o[6:5] == 2'b01));

endmodule

bind irq_source_resolver irq_source_resolver_chk u_chk (.*);

// File: tb/sim_irq_source_resolver.sv
`timescale 1ns/1ps
module sim_irq_source_resolver;

  logic        clk;
  logic        rst_n;
  logic        smp;
  logic [31:0] p0, p1, p2;
  logic        done, valid, err;
  logic [6:0]  code;

  int checks = 0;
  int errors = 0;

  irq_source_resolver u0 (
    .clk(clk), .rst_n(rst_n), .sample_i(smp),
    .pend0_i(p0), .pend1_i(p1), .pend2_i(p2),
    .done_o(done), .valid_o(valid), .err_o(err), .code_o(code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lowbit(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) ;
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return -1;
  endfunction

  function automatic int map1(input int p);
    case (p)
      0: return 7;  1: return 9;  2: return 10;
      3: return 18; default: return 19;
    endcase
  endfunction

  function automatic int map2(input int p);
    case (p)
      0: return 21; 1: return 22; 2: return 23;
      3: return 24; 4: return 25; default: return 30;
    endcase
  endfunction

  // expected {valid, err, code}
  function automatic logic [8:0] model(input logic [31:0] a, b, c);
    int k;
    k = lowbit({24'd0, a[7:0]});
    if (k >= 0) return {2'b10, 7'(k)};
    k = lowbit({27'd0, a[14:10]});
    if (k >= 0) return {2'b10, 7'(32 + map1(k))};
    k = lowbit({26'd0, a[20:15]});
    if (k >= 0) return {2'b10, 7'(64 + map2(k))};
    if (a[8]) begin
      k = lowbit(b);
      if (k >= 0) return {2'b10, 7'(32 + k)};
      return {2'b01, 7'd0};
    end
    if (a[9]) begin
      k = lowbit(c);
      if (k >= 0) return {2'b10, 7'(64 + k)};
      return {2'b01, 7'd0};
    end
    return 9'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, b, c, input string tag);
    logic [8:0] e;
    e = model(a, b, c);
    @(negedge clk);
    p0 = a; p1 = b; p2 = c; smp = 1'b1;
    @(negedge clk);
    smp = 1'b0;
    chk(done == 1'b1, "R2 done pulse", 32'(done), 32'd1);
    chk({valid, err, code} == e, tag, 32'({valid, err, code}), 32'(e));
    p0 = ~a; p1 = ~b; p2 = ~c;
    @(negedge clk);
    chk(done == 1'b0 && {valid, err, code} == e, "R2 hold without strobe",
        32'({done, valid, err, code}), 32'(e));
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; smp = 1'b0; p0 = '1; p1 = '1; p2 = '1;
    repeat (3) @(negedge clk);
    chk({done, valid, err, code} == 10'd0, "R1 in reset", 32'({done, valid, err, code}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({done, valid, err, code} == 10'd0, "R1 after release", 32'({done, valid, err, code}), 32'd0);

    // single bank 0 bit, with and without cascaded content
    for (int k = 0; k < 32; k++) begin
      run(32'd1 << k, 32'h0100_0400, 32'h8000_0010, "R5 R6 R7 R8 R9 R3 single bit");
      run(32'd1 << k, 32'd0, 32'd0, "R10 R4 single bit empty banks");
    end

    // ignored upper bits only
    run(32'hFFE0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 upper bits ignored");
    run(32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 nothing pending");

    // all pairs in the valid field, with upper garbage
    lf = 32'hACE1_2345;
    for (int i = 0; i < 21; i++) begin
      for (int j = i + 1; j < 21; j++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        run((32'd1 << i) | (32'd1 << j) | (lf & 32'hFFE0_0000),
            lf, {lf[15:0], lf[31:16]}, "R5 R6 R7 R8 R9 pair order");
      end
    end

    // lowest set bit in each cascaded word
    for (int k = 0; k < 32; k++) begin
      run(32'h0000_0100, (32'd1 << k) | 32'h8000_0000, 32'h1, "R8 bank 1 lowest bit");
      run(32'h0000_0200, 32'h1, (32'd1 << k) | 32'h8000_0000, "R9 bank 2 lowest bit");
    end

    // summary with empty bank word: error, no fall-through
    run(32'h0000_0300, 32'd0, 32'h0000_0004, "R10 empty bank 1 stops search");
    run(32'h0000_0200, 32'h0000_0004, 32'd0, "R10 empty bank 2");
    run(32'h0000_0300, 32'h0000_0020, 32'd0, "R8 summary 1 before summary 2");
    chk(!(valid && err), "R11 flags exclusive", 32'({valid, err}), 32'd0);

    // back-to-back strobes
    @(negedge clk);
    p0 = 32'h0000_0400; p1 = 0; p2 = 0; smp = 1'b1;
    @(negedge clk);
    p0 = 32'h0010_0000;
    chk(done && valid && code == 7'(32 + 7), "R6 first of back-to-back", 32'(code), 32'(39));
    @(negedge clk);
    smp = 1'b0;
    chk(done && valid && code == 7'(64 + 30), "R7 second of back-to-back", 32'(code), 32'(94));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule